// File: doc/BRIEF.md
# Prefetch Screen and Queue

This block sits between instruction issue and the data-cache prefetch engine. Every prefetch that issues is screened at once. An illegal function code, or an active watchpoint match, raises a trap. A request that names a reserved internal address space is dropped on the spot. Everything else goes into a short queue.

When an entry reaches the head of the queue, the block looks at the translation status that the memory unit reports for it. That status is a miss, translation switched off, or a page that cannot be cached. The block also checks the function-code class and whether the alternate space is one that may be prefetched. Any entry that fails these checks is retired silently. An entry that passes becomes a request for a cache line, with the function code attached. The request is held until the downstream side takes it.

Top module: `pfq_top`

## Requirements
- R1: Function codes 0 to 4 each produce exactly one request with `req_fcn` equal to the code. Requests leave in issue order.
- R2: An accepted issue with a function code from 5 to 15 gives a trap with cause 0 (illegal) in the cycle after acceptance. It never produces a request.
- R3: Function codes 16 to 31 produce neither a request nor a trap.
- R4: With `iss_alt`=1, space identifiers 0x40 to 0x6F, 0x76 and 0x77 produce neither a request nor a trap.
- R5: With `iss_alt`=1, only space identifiers 0x04, 0x0C, 0x10, 0x11, 0x18, 0x19, 0x80 to 0x83 and 0x88 to 0x8B may produce a request. Any other identifier gives no request and no trap. When `iss_alt`=0 the identifier is ignored.
- R6: While the head entry sees `xl_miss`=1, `xl_en`=0 or `xl_nocache`=1, it is retired with no request and no trap.
- R7: Bits [4:0] of `req_addr` are always zero and the upper address bits pass through unchanged. A misaligned address never traps.
- R8: An issue with `iss_wp_hit`=1 and a function code outside 5 to 15 traps with cause 1 (watchpoint) and gives no request. When the code is illegal, cause 0 takes priority.
- R9: The queue holds 4 entries, and the request stage holds one more. With `req_ready` held low, `iss_ready` drops after the fifth accepted request-producing issue.
- R10: While `req_valid`=1 and `req_ready`=0, `req_valid`, `req_fcn` and `req_addr` stay unchanged into the next cycle.
- R11: After reset, `req_valid`=0, `trap_valid`=0 and `iss_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A prefetch is being offered |
| iss_ready | output | 1 | Block can accept an issue (queue not full) |
| iss_fcn | input | 5 | Prefetch function code |
| iss_addr | input | ADDR_W | Effective address |
| iss_alt | input | 1 | Alternate-space form |
| iss_asi | input | 8 | Space identifier (used when iss_alt=1) |
| iss_wp_hit | input | 1 | Watchpoint matched this access |
| xl_miss | input | 1 | Translation miss for the head entry |
| xl_en | input | 1 | Data translation enabled |
| xl_nocache | input | 1 | Head entry page is noncacheable |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 1 | 0 illegal function, 1 watchpoint |
| req_valid | output | 1 | Prefetch request pending |
| req_ready | input | 1 | Downstream accepts the request |
| req_fcn | output | 3 | Function code of the request |
| req_addr | output | ADDR_W | Line-aligned address |

## Verification
A queue pointer that is out of step shows up at the request port within a few cycles. It appears as a repeated, missing or reordered request, and the in-order scoreboard catches it. A wrong full count shows as `iss_ready` falling too early or too late during the stalled-downstream phase. Misclassification at issue or at the head appears as a trap or request where none was expected. It is seen one cycle after acceptance for traps, and two for requests. A request register that does not hold shows as changed address or code while `req_ready` is low.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic {
        CAUSE_ILLEGAL = 1'b0,
        CAUSE_WATCH   = 1'b1
    } trap_cause_e;

    localparam int FCN_W = 5;
    localparam int ASI_W = 8;

    // function codes reserved for an illegal-instruction trap
    function automatic logic fcn_illegal(input logic [FCN_W-1:0] f);
        return (f >= 5'd5) && (f <= 5'd15);
    endfunction

    // function codes that are real prefetch operations
    function automatic logic fcn_real(input logic [FCN_W-1:0] f);
        return f <= 5'd4;
    endfunction

    // internal spaces: never queued, never executed
    function automatic logic asi_blocked(input logic [ASI_W-1:0] a);
        return ((a >= 8'h40) && (a <= 8'h6F)) || (a == 8'h76) || (a == 8'h77);
    endfunction

    // spaces for which an alternate-space prefetch is honoured
    function automatic logic asi_allowed(input logic [ASI_W-1:0] a);
        return (a == 8'h04) || (a == 8'h0C) || (a == 8'h10) || (a == 8'h11) ||
               (a == 8'h18) || (a == 8'h19) ||
               ((a >= 8'h80) && (a <= 8'h83)) ||
               ((a >= 8'h88) && (a <= 8'h8B));
    endfunction

endpackage

// File: rtl/pfq_issue_screen.sv
module pfq_issue_screen
    import pfq_pkg::*;
(
    input  logic [FCN_W-1:0] fcn,
    input  logic             alt,
    input  logic [ASI_W-1:0] asi,
    input  logic             wp_hit,
    output logic             trap_hit,
    output trap_cause_e      trap_why,
    output logic             push_ok
);
    always_comb begin
        trap_hit = 1'b0;
        trap_why = CAUSE_ILLEGAL;
        push_ok  = 1'b0;
        if (fcn_illegal(fcn)) begin
            trap_hit = 1'b1;
            trap_why = CAUSE_ILLEGAL;
        end else if (wp_hit) begin
            trap_hit = 1'b1;
            trap_why = CAUSE_WATCH;
        end else if (!(alt && asi_blocked(asi))) begin
            push_ok = 1'b1;
        end
    end
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] rdata
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign rdata   = mem_q[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = bump(st_q.wp);
        if (do_pop)  st_d.rp = bump(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/pfq_head_screen.sv
module pfq_head_screen
    import pfq_pkg::*;
(
    input  logic             fcn_hi,
    input  logic             alt,
    input  logic [ASI_W-1:0] asi,
    input  logic             xl_miss,
    input  logic             xl_en,
    input  logic             xl_nocache,
    output logic             discard
);
    logic xlate_bad, space_bad;

    always_comb begin
        xlate_bad = xl_miss || !xl_en || xl_nocache;
        space_bad = alt && !asi_allowed(asi);
        discard   = fcn_hi || xlate_bad || space_bad;
    end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
    import pfq_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int DEPTH     = 4,
    parameter int LINE_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [4:0]        iss_fcn,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              iss_alt,
    input  logic [7:0]        iss_asi,
    input  logic              iss_wp_hit,
    input  logic              xl_miss,
    input  logic              xl_en,
    input  logic              xl_nocache,
    output logic              trap_valid,
    output logic              trap_cause,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_fcn,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int ENT_W = FCN_W + ADDR_W + 1 + ASI_W;

    typedef struct packed {
        logic              trap_v;
        logic              trap_c;
        logic              req_v;
        logic [2:0]        req_fcn;
        logic [ADDR_W-1:0] req_addr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              trap_hit, push_ok, iss_fire;
    trap_cause_e       trap_why;
    logic              q_full, q_empty, q_push, q_pop;
    logic [ENT_W-1:0]  q_wdata, q_rdata;
    logic [FCN_W-1:0]  hd_fcn;
    logic [ADDR_W-1:0] hd_addr;
    logic              hd_alt, hd_discard, hd_load;
    logic [ASI_W-1:0]  hd_asi;

    pfq_issue_screen u_iss (
        .fcn      (iss_fcn),
        .alt      (iss_alt),
        .asi      (iss_asi),
        .wp_hit   (iss_wp_hit),
        .trap_hit (trap_hit),
        .trap_why (trap_why),
        .push_ok  (push_ok)
    );

    assign iss_ready = !q_full;
    assign iss_fire  = iss_valid && iss_ready;
    assign q_push    = iss_fire && push_ok;
    assign q_wdata   = {iss_fcn, iss_addr, iss_alt, iss_asi};

    pfq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (q_wdata),
        .pop   (q_pop),
        .full  (q_full),
        .empty (q_empty),
        .rdata (q_rdata)
    );

    assign {hd_fcn, hd_addr, hd_alt, hd_asi} = q_rdata;

    pfq_head_screen u_head (
        .fcn_hi     (!fcn_real(hd_fcn)),
        .alt        (hd_alt),
        .asi        (hd_asi),
        .xl_miss    (xl_miss),
        .xl_en      (xl_en),
        .xl_nocache (xl_nocache),
        .discard    (hd_discard)
    );

    assign hd_load = !q_empty && !hd_discard && (!st_q.req_v || req_ready);
    assign q_pop   = !q_empty && (hd_discard || hd_load);

    always_comb begin
        st_d        = st_q;
        st_d.trap_v = iss_fire && trap_hit;
        st_d.trap_c = trap_why;
        if (st_q.req_v && req_ready) st_d.req_v = 1'b0;
        if (hd_load) begin
            st_d.req_v    = 1'b1;
            st_d.req_fcn  = hd_fcn[2:0];
            st_d.req_addr = {hd_addr[ADDR_W-1:LINE_BITS], {LINE_BITS{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_valid = st_q.trap_v;
    assign trap_cause = st_q.trap_c;
    assign req_valid  = st_q.req_v;
    assign req_fcn    = st_q.req_fcn;
    assign req_addr   = st_q.req_addr;
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
    parameter int ADDR_W    = 40,
    parameter int LINE_BITS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [4:0]        iss_fcn,
    input logic              iss_wp_hit,
    input logic              trap_valid,
    input logic              trap_cause,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_fcn,
    input logic [ADDR_W-1:0] req_addr
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_fcn));

    p_req_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[LINE_BITS-1:0] == '0));

    p_req_fcn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_fcn <= 3'd4));

    p_trap_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_cause |->
            $past(iss_valid && iss_ready && (iss_fcn >= 5'd5) && (iss_fcn <= 5'd15)));

    p_trap_watch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_cause |->
            $past(iss_valid && iss_ready && iss_wp_hit && !((iss_fcn >= 5'd5) && (iss_fcn <= 5'd15))));
endmodule

bind pfq_top pfq_chk #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_fcn    (iss_fcn),
    .iss_wp_hit (iss_wp_hit),
    .trap_valid (trap_valid),
    .trap_cause (trap_cause),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_fcn    (req_fcn),
    .req_addr   (req_addr)
);

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic          iss_ready;
    logic [4:0]    iss_fcn = '0;
    logic [AW-1:0] iss_addr = '0;
    logic          iss_alt = 1'b0;
    logic [7:0]    iss_asi = '0;
    logic          iss_wp_hit = 1'b0;
    logic          xl_miss = 1'b0;
    logic          xl_en = 1'b1;
    logic          xl_nocache = 1'b0;
    logic          trap_valid, trap_cause;
    logic          req_valid;
    logic          req_ready = 1'b1;
    logic [2:0]    req_fcn;
    logic [AW-1:0] req_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [AW+2:0] exp_req[$];
    logic          exp_trap[$];

    always #2.5 clk = ~clk;

    pfq_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_fcn(iss_fcn),
        .iss_addr(iss_addr), .iss_alt(iss_alt), .iss_asi(iss_asi),
        .iss_wp_hit(iss_wp_hit), .xl_miss(xl_miss), .xl_en(xl_en),
        .xl_nocache(xl_nocache), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .req_valid(req_valid), .req_ready(req_ready), .req_fcn(req_fcn),
        .req_addr(req_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic blocked(input logic [7:0] a);
        return (a inside {[8'h40:8'h6F]}) || a == 8'h76 || a == 8'h77;
    endfunction

    function automatic logic allowed(input logic [7:0] a);
        return a inside {8'h04, 8'h0C, 8'h10, 8'h11, 8'h18, 8'h19,
                         [8'h80:8'h83], [8'h88:8'h8B]};
    endfunction

    // driver: offers one issue, builds the expectation from the requirements
    task automatic issue(input logic [4:0] f, input logic [AW-1:0] a,
                         input logic alt, input logic [7:0] asi, input logic wp);
        @(negedge clk);
        iss_valid = 1'b1; iss_fcn = f; iss_addr = a;
        iss_alt = alt; iss_asi = asi; iss_wp_hit = wp;
        while (!iss_ready) @(negedge clk);
        if (f >= 5 && f <= 15)             exp_trap.push_back(1'b0);      // R2
        else if (wp)                        exp_trap.push_back(1'b1);      // R8
        else if (alt && blocked(asi))       ;                              // R4
        else if (f >= 16 || xl_miss || !xl_en || xl_nocache ||
                 (alt && !allowed(asi)))    ;                              // R3 R5 R6
        else exp_req.push_back({f[2:0], a[AW-1:5], 5'b0});                 // R1 R7
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        iss_valid = 1'b0; iss_wp_hit = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares every trap and every accepted request in order
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && trap_valid) begin
                if (exp_trap.size() == 0) check("R2/R8 unexpected trap", 64'(trap_cause), 64'hFF);
                else check("R2/R8 trap cause", 64'(trap_cause), 64'(exp_trap.pop_front()));
            end
            if (rst_n && req_valid && req_ready) begin
                if (exp_req.size() == 0) check("R1/R3/R4/R5/R6 unexpected request",
                                               64'({req_fcn, req_addr}), 64'hDEAD);
                else check("R1/R7 request fcn+addr", 64'({req_fcn, req_addr}),
                           64'(exp_req.pop_front()));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [AW+2:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 req_valid after reset", 64'(req_valid), 64'd0);
        check("R11 trap_valid after reset", 64'(trap_valid), 64'd0);
        check("R11 iss_ready after reset", 64'(iss_ready), 64'd1);

        // R1 R7: each real code, misaligned addresses
        for (int f = 0; f <= 4; f++) issue(5'(f), 40'h12_3456_7800 + 40'(f * 7 + 3), 1'b0, 8'h00, 1'b0);
        idle(8);

        // R2: illegal codes trap; R3: high codes are silent
        issue(5'd5, 40'h100, 1'b0, 8'h0, 1'b0);
        issue(5'd15, 40'h200, 1'b0, 8'h0, 1'b0);
        issue(5'd16, 40'h300, 1'b0, 8'h0, 1'b0);
        issue(5'd31, 40'h400, 1'b0, 8'h0, 1'b0);
        issue(5'd1, 40'h51F, 1'b0, 8'h0, 1'b0);
        idle(8);

        // R4: internal spaces dropped at issue
        issue(5'd0, 40'h600, 1'b1, 8'h45, 1'b0);
        issue(5'd0, 40'h600, 1'b1, 8'h5F, 1'b0);
        issue(5'd0, 40'h600, 1'b1, 8'h60, 1'b0);
        issue(5'd0, 40'h600, 1'b1, 8'h76, 1'b0);
        issue(5'd0, 40'h600, 1'b1, 8'h77, 1'b0);
        issue(5'd2, 40'h7E0, 1'b0, 8'h00, 1'b0);
        idle(8);

        // R5: permitted and non-permitted spaces, identifier ignored when not alternate
        issue(5'd3, 40'h1000, 1'b1, 8'h04, 1'b0);
        issue(5'd3, 40'h1020, 1'b1, 8'h0C, 1'b0);
        issue(5'd3, 40'h1040, 1'b1, 8'h11, 1'b0);
        issue(5'd3, 40'h1060, 1'b1, 8'h19, 1'b0);
        issue(5'd4, 40'h1080, 1'b1, 8'h83, 1'b0);
        issue(5'd4, 40'h10A0, 1'b1, 8'h88, 1'b0);
        issue(5'd4, 40'h10C0, 1'b1, 8'h8B, 1'b0);
        issue(5'd4, 40'h10E0, 1'b1, 8'h05, 1'b0);
        issue(5'd4, 40'h1100, 1'b1, 8'h84, 1'b0);
        issue(5'd4, 40'h1120, 1'b1, 8'h12, 1'b0);
        issue(5'd0, 40'h1140, 1'b0, 8'h50, 1'b0);
        idle(10);

        // R6: translation conditions silence the head entry
        xl_miss = 1'b1;   issue(5'd0, 40'h2000, 1'b0, 8'h0, 1'b0); idle(6); xl_miss = 1'b0;
        xl_en = 1'b0;     issue(5'd1, 40'h2100, 1'b0, 8'h0, 1'b0); idle(6); xl_en = 1'b1;
        xl_nocache = 1'b1; issue(5'd2, 40'h2200, 1'b0, 8'h0, 1'b0); idle(6); xl_nocache = 1'b0;
        issue(5'd3, 40'h2300, 1'b0, 8'h0, 1'b0);
        idle(6);

        // R8: watchpoint trap and illegal-code priority
        issue(5'd1, 40'h3000, 1'b0, 8'h0, 1'b1);
        issue(5'd7, 40'h3000, 1'b0, 8'h0, 1'b1);
        issue(5'd18, 40'h3000, 1'b1, 8'h45, 1'b1);
        idle(6);

        // R9 R10: downstream stalled
        @(negedge clk); req_ready = 1'b0;
        for (int i = 0; i < 5; i++) issue(5'(i), 40'h4000 + 40'(i * 32 + i), 1'b0, 8'h0, 1'b0);
        idle(2);
        #1;
        check("R9 iss_ready low with 5 held", 64'(iss_ready), 64'd0);
        check("R10 req_valid while stalled", 64'(req_valid), 64'd1);
        held = {req_fcn, req_addr};
        @(negedge clk); #1;
        check("R10 request held stable", 64'({req_fcn, req_addr}), 64'(held));
        check("R9 iss_ready still low", 64'(iss_ready), 64'd0);
        @(negedge clk); req_ready = 1'b1;
        idle(12);

        check("R1 all expected requests seen", 64'(exp_req.size()), 64'd0);
        check("R2/R8 all expected traps seen", 64'(exp_trap.size()), 64'd0);
        finished = 1'b1;
        finish_run();
    end
endmodule